// File: doc/BRIEF.md
# Gated Power-Good Monitor

This block drives a single power-good output for a group of switching-regulator rails and their input supplies. Each rail reports an enable and a flag that says its output is in regulation. A rising enable starts a blanking window for that rail. The window is counted in microsecond ticks. While the window runs, the rail's regulation flag is ignored. Once the window has ended, a rail that is still out of regulation, or that leaves regulation later, raises a converter fault.

Faults also come from per-rail overvoltage flags, a die over-temperature flag, and three input-supply flags: the analog supply and two external monitors. Every fault latches into a sticky bit. Software clears a fault by pulsing a write-one-to-clear strobe, and there are three separate clear vectors. Power-good is the registered NOR of every latched fault and every supply flag that is currently invalid, so it reads good from reset onward.

A wire-OR of power-good onto the regulators' enable line can therefore shut the system down on any fault that is not expected during start-up.

Top module: `pg_gate_monitor`

## Requirements
- R1: While reset is held and in the cycle after it is released, `pg_good` is 1 and every fault bit is 0.
- R2: When `mode_sel` is 0, gated monitoring is active. When `mode_sel` is 1, no new fault bit is latched, but `pg_good` still follows `sup_ok` and any faults already latched.
- R3: A rail's blanking window lasts `BLANK_TICKS` cycles in which that rail is enabled and `tick_us` is 1. Cycles in which `tick_us` is 0 do not advance the window. No converter fault is latched while the window runs.
- R4: Suppose rail i is enabled and invalid from the clock edge on which its enable is first seen. After `BLANK_TICKS` such ticked edges, the next edge sets `conv_flt[i]`, and the edge after that drives `pg_good` to 0.
- R5: A disabled rail never raises a converter fault, and its window count returns to zero. Re-enabling the rail starts a full new window.
- R6: If `sup_ok[k]` is 0, `diag_flt[k]` latches on the next edge and `pg_good` is 0 after that same edge. Bit 0 is the analog supply, bit 1 is monitor 1 and bit 2 is monitor 2.
- R7: `ovt_flt[i]` latches on the edge after `rail_ov[i]` is 1 while rail i is enabled, with no blanking. `ovt_flt[N_RAIL]` latches on the edge after `therm_hot` is 1. An overvoltage flag on a disabled rail is ignored.
- R8: Writing 1 to a bit of `clr_top`, `clr_conv` or `clr_diag` clears the matching bit of `ovt_flt`, `conv_flt` or `diag_flt` on the next edge. Once nothing else is pending, `pg_good` returns to 1 one edge later. Fault bits never clear without a strobe.
- R9: If a clear strobe and a fault condition for the same bit meet on the same edge, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| mode_sel | input | 1 | 0 selects gated monitoring |
| rail_en | input | N_RAIL | Per-rail enable |
| rail_ok | input | N_RAIL | Per-rail output within regulation |
| rail_ov | input | N_RAIL | Per-rail overvoltage flag |
| therm_hot | input | 1 | Die over-temperature flag |
| sup_ok | input | 3 | Supply valid: [0] analog, [1] monitor 1, [2] monitor 2 |
| clr_top | input | N_RAIL+1 | W1C for ovt_flt |
| clr_conv | input | N_RAIL | W1C for conv_flt |
| clr_diag | input | 3 | W1C for diag_flt |
| pg_good | output | 1 | Registered power-good, 1 = good |
| ovt_flt | output | N_RAIL+1 | Latched overvoltage faults, thermal fault in the top bit |
| conv_flt | output | N_RAIL | Latched converter (regulation) faults |
| diag_flt | output | 3 | Latched supply faults |

## Verification
The latency from each stimulus to its result differs by source:
- A fault bit appears one edge after its condition.
- `pg_good` drops on the edge after a supply flag goes invalid, but only on the second edge after a rail condition, because the rail condition must latch first.
- A window ends after exactly `BLANK_TICKS` ticked edges.

The bench drives inputs on the falling edge and advances a counted number of rising edges before it samples. It checks the edges just before and just after each expected change. The table rows hold each input for two edges, so the result of every row is settled when it is sampled.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam int N_SUP = 3;
  localparam int SUP_ANALOG = 0;
  localparam int SUP_MON1 = 1;
  localparam int SUP_MON2 = 2;
endpackage

// File: rtl/pgm_blank_timer.sv
module pgm_blank_timer #(
  parameter int BLANK_TICKS = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(BLANK_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(BLANK_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign expired = en && (cnt == LIMIT);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);
  p_tick_gates_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> (cnt == $past(cnt)) || !en);
  p_fresh_window_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !$past(en)) |-> !expired);
endmodule

// File: rtl/pgm_w1c_bank.sv
module pgm_w1c_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else q <= (q & ~clr) | set;
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((q & $past(set)) == $past(set)));
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(q) & ~$past(clr)) & ~q) == '0));
endmodule

// File: rtl/pg_gate_monitor.sv
module pg_gate_monitor #(
  parameter int N_RAIL = 4,
  parameter int BLANK_TICKS = 800
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick_us,
  input  logic                     mode_sel,
  input  logic [N_RAIL-1:0]        rail_en,
  input  logic [N_RAIL-1:0]        rail_ok,
  input  logic [N_RAIL-1:0]        rail_ov,
  input  logic                     therm_hot,
  input  logic [pgm_pkg::N_SUP-1:0] sup_ok,
  input  logic [N_RAIL:0]          clr_top,
  input  logic [N_RAIL-1:0]        clr_conv,
  input  logic [pgm_pkg::N_SUP-1:0] clr_diag,
  output logic                     pg_good,
  output logic [N_RAIL:0]          ovt_flt,
  output logic [N_RAIL-1:0]        conv_flt,
  output logic [pgm_pkg::N_SUP-1:0] diag_flt
);
  import pgm_pkg::*;

  logic              gated;
  logic [N_RAIL-1:0] expired;
  logic [N_RAIL-1:0] conv_set;
  logic [N_RAIL:0]   ovt_set;
  logic [N_SUP-1:0]  diag_set;
  logic              any_flt;

  assign gated = !mode_sel;

  for (genvar i = 0; i < N_RAIL; i++) begin : g_rail
    pgm_blank_timer #(.BLANK_TICKS(BLANK_TICKS)) u_tmr (
      .clk(clk), .rst(rst), .en(rail_en[i]), .tick(tick_us), .expired(expired[i])
    );
  end

  assign conv_set = {N_RAIL{gated}} & expired & ~rail_ok;
  assign ovt_set  = {gated & therm_hot, {N_RAIL{gated}} & rail_en & rail_ov};
  assign diag_set = {N_SUP{gated}} & ~sup_ok;

  pgm_w1c_bank #(.W(N_RAIL + 1)) u_ovt (
    .clk(clk), .rst(rst), .set(ovt_set), .clr(clr_top), .q(ovt_flt)
  );
  pgm_w1c_bank #(.W(N_RAIL)) u_conv (
    .clk(clk), .rst(rst), .set(conv_set), .clr(clr_conv), .q(conv_flt)
  );
  pgm_w1c_bank #(.W(N_SUP)) u_diag (
    .clk(clk), .rst(rst), .set(diag_set), .clr(clr_diag), .q(diag_flt)
  );

  assign any_flt = (|ovt_flt) | (|conv_flt) | (|diag_flt);

  always_ff @(posedge clk) begin
    if (rst) pg_good <= 1'b1;
    else pg_good <= !(any_flt || !(&sup_ok));
  end

  p_supply_drop_r6: assert property (@(posedge clk) disable iff (rst)
    !(&sup_ok) |=> !pg_good);
  p_fault_holds_low_r4: assert property (@(posedge clk) disable iff (rst)
    any_flt |=> !pg_good);
  p_mode_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    mode_sel |=> ((conv_flt & ~$past(conv_flt)) == '0) &&
                 ((diag_flt & ~$past(diag_flt)) == '0) &&
                 ((ovt_flt & ~$past(ovt_flt)) == '0));
  p_blank_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    ((conv_flt & ~$past(conv_flt)) & ~$past(expired)) == '0);
endmodule

// File: tb/tb_pg_gate_monitor.sv
module tb_pg_gate_monitor;
  localparam int NR = 2;
  localparam int B = 8;

  logic clk = 0, rst = 1, tick_us = 1, mode_sel = 0, therm_hot = 0;
  logic [NR-1:0] rail_en = '0, rail_ok = '1, rail_ov = '0, clr_conv = '0;
  logic [2:0] sup_ok = 3'b111, clr_diag = '0;
  logic [NR:0] clr_top = '0;
  logic pg_good;
  logic [NR:0] ovt_flt;
  logic [NR-1:0] conv_flt;
  logic [2:0] diag_flt;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pg_gate_monitor #(.N_RAIL(NR), .BLANK_TICKS(B)) dut (
    .clk(clk), .rst(rst), .tick_us(tick_us), .mode_sel(mode_sel),
    .rail_en(rail_en), .rail_ok(rail_ok), .rail_ov(rail_ov), .therm_hot(therm_hot),
    .sup_ok(sup_ok), .clr_top(clr_top), .clr_conv(clr_conv), .clr_diag(clr_diag),
    .pg_good(pg_good), .ovt_flt(ovt_flt), .conv_flt(conv_flt), .diag_flt(diag_flt)
  );

  // row: {valid[1:0], sup[2:0], clrc[1:0], clrd[2:0], pg, conv[1:0], diag[2:0]}
  localparam int NROW = 12;
  localparam logic [15:0] ROWS [NROW] = '{
    {2'b11, 3'b111, 2'b00, 3'b000, 1'b1, 2'b00, 3'b000},
    {2'b10, 3'b111, 2'b00, 3'b000, 1'b0, 2'b01, 3'b000},
    {2'b11, 3'b111, 2'b00, 3'b000, 1'b0, 2'b01, 3'b000},
    {2'b11, 3'b111, 2'b01, 3'b000, 1'b1, 2'b00, 3'b000},
    {2'b11, 3'b111, 2'b00, 3'b000, 1'b1, 2'b00, 3'b000},
    {2'b11, 3'b101, 2'b00, 3'b000, 1'b0, 2'b00, 3'b010},
    {2'b11, 3'b111, 2'b00, 3'b000, 1'b0, 2'b00, 3'b010},
    {2'b11, 3'b111, 2'b00, 3'b010, 1'b1, 2'b00, 3'b000},
    {2'b01, 3'b111, 2'b10, 3'b000, 1'b0, 2'b10, 3'b000},
    {2'b11, 3'b111, 2'b10, 3'b000, 1'b1, 2'b00, 3'b000},
    {2'b00, 3'b011, 2'b00, 3'b000, 1'b0, 2'b11, 3'b100},
    {2'b11, 3'b111, 2'b11, 3'b111, 1'b1, 2'b00, 3'b000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset;
    rst = 1; rail_en = '0; rail_ok = '1; rail_ov = '0; therm_hot = 0;
    sup_ok = 3'b111; clr_top = '0; clr_conv = '0; clr_diag = '0;
    mode_sel = 0; tick_us = 1;
    step(3);
    rst = 0;
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    step(2);
    // R1 during and after reset
    chk("R1 pg in reset", pg_good, 1);
    do_reset();
    step(1);
    chk("R1 pg after reset", pg_good, 1);
    chk("R1 faults after reset", {ovt_flt, conv_flt, diag_flt}, 0);

    // R4 window timing
    rail_en = 2'b01; rail_ok = 2'b10;
    step(B);
    chk("R3 no fault inside window", conv_flt, 0);
    step(1);
    chk("R4 conv fault after window", conv_flt, 2'b01);
    chk("R4 pg still high one edge", pg_good, 1);
    step(1);
    chk("R4 pg low", pg_good, 0);

    // R8 clear with condition gone
    rail_en = 2'b00; clr_conv = 2'b01;
    step(1);
    clr_conv = 0;
    chk("R8 conv cleared", conv_flt, 0);
    step(1);
    chk("R8 pg restored", pg_good, 1);

    // R5 disabled rail, restart window
    step(20);
    chk("R5 disabled rail no fault", conv_flt, 0);
    rail_en = 2'b01; step(B - 2);
    rail_en = 2'b00; step(1);
    rail_en = 2'b01; step(B);
    chk("R5 window restarted", conv_flt, 0);
    step(1);
    chk("R5 fault after fresh window", conv_flt, 2'b01);
    rail_en = 0; clr_conv = 2'b01; step(1); clr_conv = 0; step(1);

    // R3 tick gating
    tick_us = 0; rail_en = 2'b01;
    step(30);
    chk("R3 no ticks no fault", conv_flt, 0);
    chk("R3 pg high without ticks", pg_good, 1);
    tick_us = 1; step(B);
    chk("R3 window counts ticks only", conv_flt, 0);
    step(1);
    chk("R3 fault after ticked window", conv_flt, 2'b01);
    rail_en = 0; clr_conv = 2'b01; step(1); clr_conv = 0; step(1);
    rail_ok = '1;

    // R7 overvoltage and thermal
    rail_ov = 2'b10; step(1);
    chk("R7 ov on disabled rail ignored", ovt_flt, 0);
    rail_en = 2'b10; step(1);
    chk("R7 ov latched without blanking", ovt_flt, 3'b010);
    rail_ov = 0; therm_hot = 1; step(1);
    chk("R7 thermal latched", ovt_flt, 3'b110);
    therm_hot = 0; clr_top = 3'b111; step(1); clr_top = 0;
    chk("R8 top clear", ovt_flt, 0);
    step(1);
    chk("R8 pg after top clear", pg_good, 1);
    rail_en = 0; step(1);

    // R2 mode select
    mode_sel = 1; rail_en = 2'b01; rail_ok = 2'b10;
    step(B + 4);
    chk("R2 mode 1 no conv fault", conv_flt, 0);
    chk("R2 mode 1 pg high", pg_good, 1);
    sup_ok = 3'b110; step(1);
    chk("R2 mode 1 pg follows supply", pg_good, 0);
    chk("R2 mode 1 no diag latch", diag_flt, 0);
    sup_ok = 3'b111; step(1);
    chk("R2 mode 1 pg recovers", pg_good, 1);
    mode_sel = 0; step(1);
    chk("R2 mode 0 latches expired fault", conv_flt, 2'b01);

    // R6 supply timing
    do_reset();
    sup_ok = 3'b011; step(1);
    chk("R6 diag latch one edge", diag_flt, 3'b100);
    chk("R6 pg low one edge", pg_good, 0);

    // table phase
    do_reset();
    rail_en = 2'b11;
    step(B + 2);
    for (int r = 0; r < NROW; r++) begin
      rail_ok  = ROWS[r][15:14];
      sup_ok   = ROWS[r][13:11];
      clr_conv = ROWS[r][10:9];
      clr_diag = ROWS[r][8:6];
      step(2);
      // R4 R6 R8 R9 per row
      chk($sformatf("R4 R6 R8 R9 row %0d pg", r), pg_good, ROWS[r][5]);
      chk($sformatf("R4 R9 row %0d conv", r), conv_flt, ROWS[r][4:3]);
      chk($sformatf("R6 R8 row %0d diag", r), diag_flt, ROWS[r][2:0]);
    end
    clr_conv = 0; clr_diag = 0;
    finish_run();
  end
endmodule